// File: doc/BRIEF.md
# Multi-Dimensional Tile Copy Engine

This block moves one rectangular tile, of one to five dimensions, between a large byte-addressed global memory and a small local scratch memory. A load copies from global memory into scratch; a store copies from scratch back to global memory. The tile shape and the tensor layout come from a descriptor: dimension count, per-dimension box size, per-dimension byte stride, element size and the tensor's global base address. The command itself carries the direction, one start coordinate per dimension, the scratch base address and a barrier handle.

Start coordinates are element indices into the tensor, not tile numbers: in one dimension, the second tile of 16 elements starts at coordinate 16. The engine walks the box with dimension 0 innermost. For each element it forms the global address as the base plus, for every active dimension, (coordinate + offset in box) times that dimension's stride. In scratch the tile is stored densely from the scratch base. Each move takes one cycle once both memories are ready.

Loads report progress as a stream of byte credits to the named barrier, one credit per element written to scratch. Stores emit no credits. A command whose scratch base is not 128-byte aligned, or whose shape is malformed, is refused with a one-cycle error flag and causes no memory traffic.

Top module: `tcopy_engine`

## Requirements
- R1: After reset, busy, errFlag, creditValid and all four memory strobes (glbRead, glbWrite, spmRead, spmWrite) are low and cmdReady is high.
- R2: A command is taken in a cycle with cmdValid and cmdReady high; cmdReady equals not busy. For a valid command busy is high from the next cycle through the cycle of the final element write and low in the cycle after it.
- R3: Elements are visited with dimension 0 innermost; element (i0..i4) reads or writes global address descGlbBase + sum over active dimensions d of (cmdCoord[d] + id) * descStride[d], modulo 2^32.
- R4: The k-th element visited (k from 0) uses scratch address cmdSpmBase + k * 2^descElemLog2, modulo 2^SPM_AW.
- R5: An element moves in exactly those busy cycles where glbReady and spmReady are both high; in any other cycle no write strobe is raised and the addresses hold.
- R6: A load (cmdIsStore = 0) reads global memory and writes the read word unchanged to scratch (spmWdata = glbRdata); each scratch write raises creditValid with creditBytes = 2^descElemLog2 and creditBarrier = cmdBarrier, so the credits of a command sum to the product of the active box sizes times the element size.
- R7: A store (cmdIsStore = 1) reads scratch and writes the word unchanged to global memory (glbWdata = spmRdata) and never raises creditValid.
- R8: A command whose cmdSpmBase has any of its low 7 bits set raises errFlag for exactly the next cycle, leaves busy low and produces no read or write strobe.
- R9: A command with descDims of 0 or above 5, or with a zero box size in an active dimension (index below descDims), is refused in the same way as R8.
- R10: Coordinates, strides and box sizes of dimensions at or above descDims have no effect: a zero box there is accepted and does not change the addresses or the element count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cmdValid | input | 1 | Command offered |
| cmdReady | output | 1 | Engine idle and able to take a command |
| cmdIsStore | input | 1 | 1 = scratch to global, 0 = global to scratch |
| cmdCoord | input | 5x32 | Start element coordinate per dimension |
| cmdSpmBase | input | 16 | Scratch base byte address, 128-byte aligned |
| cmdBarrier | input | 4 | Barrier handle for load credits |
| descDims | input | 3 | Number of active dimensions, 1 to 5 |
| descBox | input | 5x8 | Box size per dimension in elements |
| descStride | input | 5x32 | Byte stride per dimension |
| descElemLog2 | input | 2 | Element size as log2 of bytes (1, 2, 4, 8) |
| descGlbBase | input | 32 | Tensor base byte address in global memory |
| busy | output | 1 | Command in progress |
| errFlag | output | 1 | One-cycle pulse: command refused |
| glbAddr | output | 32 | Global byte address of current element |
| glbRead | output | 1 | Global read strobe (loads) |
| glbWrite | output | 1 | Global write strobe (stores) |
| glbWdata | output | 64 | Global write data |
| glbRdata | input | 64 | Global read data, valid with glbReady |
| glbReady | input | 1 | Global memory can complete an access this cycle |
| spmAddr | output | 16 | Scratch byte address of current element |
| spmRead | output | 1 | Scratch read strobe (stores) |
| spmWrite | output | 1 | Scratch write strobe (loads) |
| spmWdata | output | 64 | Scratch write data |
| spmRdata | input | 64 | Scratch read data, valid with spmReady |
| spmReady | input | 1 | Scratch memory can complete an access this cycle |
| creditValid | output | 1 | Byte credit issued to a barrier |
| creditBarrier | output | 4 | Barrier handle of the credit |
| creditBytes | output | 4 | Bytes credited |

## Verification
The bench builds the engine with its defaults: five dimensions, 8-bit box sizes, 32-bit global and 16-bit scratch addresses and a 128-byte alignment rule. Five dimensions make the full carry chain of the element walk reachable, including carries that ripple through several dimensions at once, while box sizes kept small by the stimulus keep each tile to a few hundred elements. The 16-bit scratch space lets random bases wrap, and random strides up to 32 bits let the global address sum overflow, so modulo behaviour of both address formulas is exercised.

// File: rtl/tcopy_pkg.sv
package tcopy_pkg;

  // Strobes from control to datapath.
  typedef struct packed {
    logic load;   // capture command and descriptor, clear the walk
    logic step;   // one element moved, advance the walk
  } dpStrobe_t;

  typedef enum logic [0:0] {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } ctrlState_t;

endpackage

// File: rtl/tcopy_ctrl.sv
module tcopy_ctrl
  import tcopy_pkg::*;
#(
  parameter int DIMS       = 5,
  parameter int BOX_W      = 8,
  parameter int ALIGN_LOG2 = 7,
  parameter int DIM_W      = $clog2(DIMS + 1)
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        cmdValid,
  input  logic                        cmdIsStore,
  input  logic [ALIGN_LOG2-1:0]       cmdSpmLow,
  input  logic [DIM_W-1:0]            descDims,
  input  logic [DIMS-1:0][BOX_W-1:0]  descBox,
  input  logic                        glbReady,
  input  logic                        spmReady,
  input  logic                        lastElem,
  output dpStrobe_t                   strobe,
  output logic                        cmdReady,
  output logic                        busy,
  output logic                        errFlag,
  output logic                        glbRead,
  output logic                        glbWrite,
  output logic                        spmRead,
  output logic                        spmWrite,
  output logic                        creditValid
);

  ctrlState_t state;
  logic       isStoreQ;
  logic       errQ;
  logic       accept;
  logic       cmdOk;
  logic       running;

  // Shape and alignment check of an offered command.
  always_comb begin
    cmdOk = (cmdSpmLow == '0) && (descDims != '0) &&
            (int'(descDims) <= DIMS);
    for (int d = 0; d < DIMS; d++) begin
      if ((d < int'(descDims)) && (descBox[d] == '0)) cmdOk = 1'b0;
    end
  end

  assign running     = (state == ST_RUN);
  assign accept      = cmdValid && !running;
  assign strobe.load = accept && cmdOk;
  assign strobe.step = running && glbReady && spmReady;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      isStoreQ <= 1'b0;
      errQ     <= 1'b0;
    end else begin
      errQ <= accept && !cmdOk;
      if (strobe.load) begin
        state    <= ST_RUN;
        isStoreQ <= cmdIsStore;
      end else if (strobe.step && lastElem) begin
        state <= ST_IDLE;
      end
    end
  end

  assign cmdReady    = !running;
  assign busy        = running;
  assign errFlag     = errQ;
  assign glbRead     = running && !isStoreQ;
  assign spmRead     = running && isStoreQ;
  assign glbWrite    = strobe.step && isStoreQ;
  assign spmWrite    = strobe.step && !isStoreQ;
  assign creditValid = spmWrite;

endmodule

// File: rtl/tcopy_datapath.sv
module tcopy_datapath
  import tcopy_pkg::*;
#(
  parameter int DIMS   = 5,
  parameter int ADDR_W = 32,
  parameter int SPM_AW = 16,
  parameter int BOX_W  = 8,
  parameter int DATA_W = 64,
  parameter int BAR_W  = 4,
  parameter int DIM_W  = $clog2(DIMS + 1),
  parameter int CNT_W  = DIMS * BOX_W
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  dpStrobe_t                   strobe,
  input  logic [DIMS-1:0][ADDR_W-1:0] cmdCoord,
  input  logic [SPM_AW-1:0]           cmdSpmBase,
  input  logic [BAR_W-1:0]            cmdBarrier,
  input  logic [DIM_W-1:0]            descDims,
  input  logic [DIMS-1:0][BOX_W-1:0]  descBox,
  input  logic [DIMS-1:0][ADDR_W-1:0] descStride,
  input  logic [1:0]                  descElemLog2,
  input  logic [ADDR_W-1:0]           descGlbBase,
  input  logic [DATA_W-1:0]           glbRdata,
  input  logic [DATA_W-1:0]           spmRdata,
  output logic                        lastElem,
  output logic [ADDR_W-1:0]           glbAddr,
  output logic [SPM_AW-1:0]           spmAddr,
  output logic [DATA_W-1:0]           glbWdata,
  output logic [DATA_W-1:0]           spmWdata,
  output logic [BAR_W-1:0]            creditBarrier,
  output logic [3:0]                  creditBytes
);

  logic [DIMS-1:0][ADDR_W-1:0] coordQ;
  logic [DIMS-1:0][ADDR_W-1:0] strideQ;
  logic [DIMS-1:0][BOX_W-1:0]  boxQ;
  logic [DIMS-1:0][BOX_W-1:0]  idxQ;
  logic [DIMS-1:0]             atEnd;
  logic [DIMS:0]               carry;
  logic [DIMS-1:0][ADDR_W-1:0] term;
  logic [ADDR_W-1:0]           glbBaseQ;
  logic [SPM_AW-1:0]           spmBaseQ;
  logic [BAR_W-1:0]            barrierQ;
  logic [1:0]                  elemLog2Q;
  logic [CNT_W-1:0]            countQ;

  assign carry[0] = 1'b1;

  // One odometer digit and one address term per dimension.
  for (genvar d = 0; d < DIMS; d++) begin : g_dim
    logic active;
    assign active       = (d < int'(descDims));
    assign atEnd[d]     = (idxQ[d] == boxQ[d] - BOX_W'(1));
    assign carry[d + 1] = carry[d] && atEnd[d];
    assign term[d]      = (coordQ[d] + ADDR_W'(idxQ[d])) * strideQ[d];

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        coordQ[d]  <= '0;
        strideQ[d] <= '0;
        boxQ[d]    <= BOX_W'(1);
        idxQ[d]    <= '0;
      end else if (strobe.load) begin
        coordQ[d]  <= active ? cmdCoord[d]   : '0;
        strideQ[d] <= active ? descStride[d] : '0;
        boxQ[d]    <= active ? descBox[d]    : BOX_W'(1);
        idxQ[d]    <= '0;
      end else if (strobe.step && carry[d]) begin
        idxQ[d] <= atEnd[d] ? '0 : idxQ[d] + BOX_W'(1);
      end
    end
  end

  assign lastElem = carry[DIMS];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      glbBaseQ  <= '0;
      spmBaseQ  <= '0;
      barrierQ  <= '0;
      elemLog2Q <= '0;
      countQ    <= '0;
    end else if (strobe.load) begin
      glbBaseQ  <= descGlbBase;
      spmBaseQ  <= cmdSpmBase;
      barrierQ  <= cmdBarrier;
      elemLog2Q <= descElemLog2;
      countQ    <= '0;
    end else if (strobe.step) begin
      countQ <= countQ + CNT_W'(1);
    end
  end

  always_comb begin
    glbAddr = glbBaseQ;
    for (int d = 0; d < DIMS; d++) glbAddr = glbAddr + term[d];
  end

  assign spmAddr       = spmBaseQ + SPM_AW'(countQ << elemLog2Q);
  assign spmWdata      = glbRdata;
  assign glbWdata      = spmRdata;
  assign creditBarrier = barrierQ;
  assign creditBytes   = 4'(1) << elemLog2Q;

endmodule

// File: rtl/tcopy_engine.sv
module tcopy_engine
  import tcopy_pkg::*;
#(
  parameter int DIMS       = 5,
  parameter int ADDR_W     = 32,
  parameter int SPM_AW     = 16,
  parameter int BOX_W      = 8,
  parameter int DATA_W     = 64,
  parameter int BAR_W      = 4,
  parameter int ALIGN_LOG2 = 7,
  parameter int DIM_W      = $clog2(DIMS + 1)
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        cmdValid,
  output logic                        cmdReady,
  input  logic                        cmdIsStore,
  input  logic [DIMS-1:0][ADDR_W-1:0] cmdCoord,
  input  logic [SPM_AW-1:0]           cmdSpmBase,
  input  logic [BAR_W-1:0]            cmdBarrier,
  input  logic [DIM_W-1:0]            descDims,
  input  logic [DIMS-1:0][BOX_W-1:0]  descBox,
  input  logic [DIMS-1:0][ADDR_W-1:0] descStride,
  input  logic [1:0]                  descElemLog2,
  input  logic [ADDR_W-1:0]           descGlbBase,
  output logic                        busy,
  output logic                        errFlag,
  output logic [ADDR_W-1:0]           glbAddr,
  output logic                        glbRead,
  output logic                        glbWrite,
  output logic [DATA_W-1:0]           glbWdata,
  input  logic [DATA_W-1:0]           glbRdata,
  input  logic                        glbReady,
  output logic [SPM_AW-1:0]           spmAddr,
  output logic                        spmRead,
  output logic                        spmWrite,
  output logic [DATA_W-1:0]           spmWdata,
  input  logic [DATA_W-1:0]           spmRdata,
  input  logic                        spmReady,
  output logic                        creditValid,
  output logic [BAR_W-1:0]            creditBarrier,
  output logic [3:0]                  creditBytes
);

  dpStrobe_t strobe;
  logic      lastElem;

  tcopy_ctrl #(
    .DIMS(DIMS), .BOX_W(BOX_W), .ALIGN_LOG2(ALIGN_LOG2), .DIM_W(DIM_W)
  ) u_ctrl (
    .clk(clk), .rstN(rstN),
    .cmdValid(cmdValid), .cmdIsStore(cmdIsStore),
    .cmdSpmLow(cmdSpmBase[ALIGN_LOG2-1:0]),
    .descDims(descDims), .descBox(descBox),
    .glbReady(glbReady), .spmReady(spmReady), .lastElem(lastElem),
    .strobe(strobe), .cmdReady(cmdReady), .busy(busy), .errFlag(errFlag),
    .glbRead(glbRead), .glbWrite(glbWrite),
    .spmRead(spmRead), .spmWrite(spmWrite), .creditValid(creditValid)
  );

  tcopy_datapath #(
    .DIMS(DIMS), .ADDR_W(ADDR_W), .SPM_AW(SPM_AW), .BOX_W(BOX_W),
    .DATA_W(DATA_W), .BAR_W(BAR_W), .DIM_W(DIM_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .cmdCoord(cmdCoord), .cmdSpmBase(cmdSpmBase), .cmdBarrier(cmdBarrier),
    .descDims(descDims), .descBox(descBox), .descStride(descStride),
    .descElemLog2(descElemLog2), .descGlbBase(descGlbBase),
    .glbRdata(glbRdata), .spmRdata(spmRdata),
    .lastElem(lastElem), .glbAddr(glbAddr), .spmAddr(spmAddr),
    .glbWdata(glbWdata), .spmWdata(spmWdata),
    .creditBarrier(creditBarrier), .creditBytes(creditBytes)
  );

endmodule

// File: rtl/tcopy_checker.sv
module tcopy_checker #(
  parameter int SPM_AW = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              busy,
  input logic              errFlag,
  input logic              glbReady,
  input logic              spmReady,
  input logic              glbRead,
  input logic              glbWrite,
  input logic              spmRead,
  input logic              spmWrite,
  input logic              creditValid,
  input logic [SPM_AW-1:0] spmAddr
);

  assert_write_needs_ready_R5: assert property (@(posedge clk) disable iff (!rstN)
    (glbWrite || spmWrite) |-> (glbReady && spmReady));

  assert_stall_holds_addr_R5: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !(glbReady && spmReady)) |=> $stable(spmAddr));

  assert_credit_on_load_write_R6: assert property (@(posedge clk) disable iff (!rstN)
    creditValid |-> (spmWrite && glbRead));

  assert_store_no_credit_R7: assert property (@(posedge clk) disable iff (!rstN)
    (glbWrite || spmRead) |-> !creditValid);

  assert_refused_quiet_R8: assert property (@(posedge clk) disable iff (!rstN)
    errFlag |-> (!busy && !glbRead && !glbWrite && !spmRead && !spmWrite));

  assert_busy_ends_on_write_R2: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> $past(glbWrite || spmWrite));

endmodule

bind tcopy_engine tcopy_checker #(.SPM_AW(SPM_AW)) u_chk (
  .clk(clk), .rstN(rstN), .busy(busy), .errFlag(errFlag),
  .glbReady(glbReady), .spmReady(spmReady),
  .glbRead(glbRead), .glbWrite(glbWrite),
  .spmRead(spmRead), .spmWrite(spmWrite),
  .creditValid(creditValid), .spmAddr(spmAddr)
);

// File: tb/tcopy_engine_test.sv
module tcopy_engine_test;

  localparam int CLK_PERIOD = 10;
  localparam int DIMS = 5;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cmdValid = 1'b0;
  logic cmdReady;
  logic cmdIsStore = 1'b0;
  logic [DIMS-1:0][31:0] cmdCoord = '0;
  logic [15:0] cmdSpmBase = '0;
  logic [3:0]  cmdBarrier = '0;
  logic [2:0]  descDims = 3'd1;
  logic [DIMS-1:0][7:0]  descBox = '0;
  logic [DIMS-1:0][31:0] descStride = '0;
  logic [1:0]  descElemLog2 = '0;
  logic [31:0] descGlbBase = '0;
  logic busy, errFlag;
  logic [31:0] glbAddr;
  logic glbRead, glbWrite;
  logic [63:0] glbWdata, glbRdata;
  logic glbReady = 1'b0;
  logic [15:0] spmAddr;
  logic spmRead, spmWrite;
  logic [63:0] spmWdata, spmRdata;
  logic spmReady = 1'b0;
  logic creditValid;
  logic [3:0] creditBarrier, creditBytes;

  int tests = 0;
  int fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  // Memory models: read data is a function of the address.
  function automatic logic [63:0] glbWord(input logic [31:0] a);
    return {a, a ^ 32'h5A5A_C3C3};
  endfunction
  function automatic logic [63:0] spmWord(input logic [15:0] a);
    return {16'hBEEF, a, 32'h1234_0000 | {16'h0, a}};
  endfunction
  assign glbRdata = glbWord(glbAddr);
  assign spmRdata = spmWord(spmAddr);

  tcopy_engine uut (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdReady(cmdReady),
    .cmdIsStore(cmdIsStore), .cmdCoord(cmdCoord), .cmdSpmBase(cmdSpmBase),
    .cmdBarrier(cmdBarrier), .descDims(descDims), .descBox(descBox),
    .descStride(descStride), .descElemLog2(descElemLog2),
    .descGlbBase(descGlbBase), .busy(busy), .errFlag(errFlag),
    .glbAddr(glbAddr), .glbRead(glbRead), .glbWrite(glbWrite),
    .glbWdata(glbWdata), .glbRdata(glbRdata), .glbReady(glbReady),
    .spmAddr(spmAddr), .spmRead(spmRead), .spmWrite(spmWrite),
    .spmWdata(spmWdata), .spmRdata(spmRdata), .spmReady(spmReady),
    .creditValid(creditValid), .creditBarrier(creditBarrier),
    .creditBytes(creditBytes)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // Expected global address from the requirement formula (R3).
  function automatic logic [31:0] expGlb(input int idx[DIMS]);
    logic [31:0] a = descGlbBase;
    for (int d = 0; d < int'(descDims); d++)
      a = a + (cmdCoord[d] + 32'(idx[d])) * descStride[d];
    return a;
  endfunction

  // Issue a valid command and follow it element by element.
  task automatic runCmd(input int readyPct);
    int idx[DIMS];
    int total = 1;
    int k = 0;
    int guard = 0;
    int creditSum = 0;
    bit st = cmdIsStore;
    logic [15:0] eSpm;
    logic [31:0] eGlb;
    for (int d = 0; d < DIMS; d++) idx[d] = 0;
    for (int d = 0; d < int'(descDims); d++) total = total * int'(descBox[d]);
    @(negedge clk);
    cmdValid = 1'b1;
    glbReady = 1'b0;
    spmReady = 1'b0;
    @(negedge clk);
    cmdValid = 1'b0;
    #1;
    check(busy === 1'b1 && cmdReady === 1'b0, "R2", "busy after accept",
          {62'b0, busy, cmdReady}, 64'd2);
    while (k < total && guard < 20000) begin
      glbReady = ($urandom_range(99) < readyPct);
      spmReady = ($urandom_range(99) < readyPct);
      #1;
      if (glbReady && spmReady) begin
        eGlb = expGlb(idx);
        eSpm = cmdSpmBase + 16'(k << descElemLog2);
        check(glbAddr === eGlb, "R3", "global address", 64'(glbAddr), 64'(eGlb));
        check(spmAddr === eSpm, "R4", "scratch address", 64'(spmAddr), 64'(eSpm));
        if (!st) begin
          check(spmWrite === 1'b1 && glbWrite === 1'b0 && glbRead === 1'b1,
                "R6", "load strobes", {61'b0, spmWrite, glbWrite, glbRead}, 64'd5);
          check(spmWdata === glbWord(eGlb), "R6", "load data", spmWdata, glbWord(eGlb));
          check(creditValid === 1'b1 && creditBarrier === cmdBarrier &&
                creditBytes === 4'(1 << descElemLog2), "R6", "credit",
                {56'b0, creditValid, 3'b0, creditBytes},
                {56'b0, 1'b1, 3'b0, 4'(1 << descElemLog2)});
          if (creditValid === 1'b1) creditSum += int'(creditBytes);
        end else begin
          check(glbWrite === 1'b1 && spmWrite === 1'b0 && spmRead === 1'b1,
                "R7", "store strobes", {61'b0, glbWrite, spmWrite, spmRead}, 64'd5);
          check(glbWdata === spmWord(eSpm), "R7", "store data", glbWdata, spmWord(eSpm));
          check(creditValid === 1'b0, "R7", "no credit on store",
                64'(creditValid), 64'd0);
        end
        k++;
        for (int d = 0; d < DIMS; d++) begin
          if (idx[d] + 1 < ((d < int'(descDims)) ? int'(descBox[d]) : 1)) begin
            idx[d]++;
            break;
          end
          idx[d] = 0;
        end
      end else begin
        check(glbWrite === 1'b0 && spmWrite === 1'b0 && busy === 1'b1,
              "R5", "stall no write", {61'b0, glbWrite, spmWrite, busy}, 64'd1);
      end
      guard++;
      @(negedge clk);
    end
    glbReady = 1'b0;
    spmReady = 1'b0;
    #1;
    check(busy === 1'b0 && cmdReady === 1'b1, "R2", "idle after last element",
          {62'b0, busy, cmdReady}, 64'd1);
    if (!st)
      check(creditSum == total * (1 << descElemLog2), "R6", "credit total",
            64'(creditSum), 64'(total * (1 << descElemLog2)));
  endtask

  // Offer a command that must be refused.
  task automatic refuseCmd(input string req);
    @(negedge clk);
    cmdValid = 1'b1;
    glbReady = 1'b1;
    spmReady = 1'b1;
    @(negedge clk);
    cmdValid = 1'b0;
    #1;
    check(errFlag === 1'b1 && busy === 1'b0 && !glbRead && !glbWrite &&
          !spmRead && !spmWrite, req, "refused command",
          {58'b0, errFlag, busy, glbRead, glbWrite, spmRead, spmWrite}, 64'h20);
    @(negedge clk);
    #1;
    check(errFlag === 1'b0 && busy === 1'b0, req, "error one cycle",
          {62'b0, errFlag, busy}, 64'd0);
    glbReady = 1'b0;
    spmReady = 1'b0;
  endtask

  task automatic randomCmd();
    descDims = 3'($urandom_range(5, 1));
    for (int d = 0; d < DIMS; d++) begin
      descBox[d]    = 8'((d == 0) ? $urandom_range(6, 1) : $urandom_range(3, 1));
      cmdCoord[d]   = $urandom();
      descStride[d] = $urandom();
    end
    descElemLog2 = 2'($urandom_range(3));
    descGlbBase  = $urandom();
    cmdSpmBase   = {9'($urandom()), 7'b0};
    cmdBarrier   = 4'($urandom());
    cmdIsStore   = 1'($urandom());
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    #1;
    check(busy === 1'b0 && errFlag === 1'b0 && creditValid === 1'b0 &&
          !glbRead && !glbWrite && !spmRead && !spmWrite && cmdReady === 1'b1,
          "R1", "reset state",
          {56'b0, busy, errFlag, creditValid, glbRead, glbWrite, spmRead, spmWrite, cmdReady},
          64'd1);
    rstN = 1'b1;

    // Directed 1D load: second 16-element tile starts at coordinate 16 (R3).
    descDims = 3'd1; descBox = '0; descBox[0] = 8'd16;
    cmdCoord = '0; cmdCoord[0] = 32'd16;
    descStride = '0; descStride[0] = 32'd4;
    descElemLog2 = 2'd2; descGlbBase = 32'h1000_0000;
    cmdSpmBase = 16'h0080; cmdBarrier = 4'd3; cmdIsStore = 1'b0;
    runCmd(100);

    // Directed 2D store with inactive dimensions holding junk and zero box (R10).
    descDims = 3'd2;
    descBox = {8'd0, 8'd0, 8'd0, 8'd3, 8'd4};
    cmdCoord = {32'hFFFF_FFFF, 32'h1234_5678, 32'd99, 32'd2, 32'd5};
    descStride = {32'h7777_0000, 32'h0000_0333, 32'd12345, 32'd256, 32'd8};
    descElemLog2 = 2'd3; descGlbBase = 32'h2000_0000;
    cmdSpmBase = 16'hFF80; cmdIsStore = 1'b1;
    runCmd(60);

    // Full five-dimensional walk with random readiness (R3, R5).
    descDims = 3'd5;
    descBox = {8'd2, 8'd2, 8'd3, 8'd2, 8'd3};
    for (int d = 0; d < DIMS; d++) begin
      cmdCoord[d] = 32'(d * 7);
      descStride[d] = 32'(1 << (4 + 3 * d));
    end
    descElemLog2 = 2'd0; cmdSpmBase = 16'h0100; cmdIsStore = 1'b0;
    runCmd(50);

    // Refusals: misaligned base (R8), bad shapes (R9).
    descDims = 3'd2; descBox = {8'd1, 8'd1, 8'd1, 8'd2, 8'd2};
    cmdSpmBase = 16'h0140;
    refuseCmd("R8");
    cmdSpmBase = 16'h0001;
    refuseCmd("R8");
    cmdSpmBase = 16'h0200;
    descDims = 3'd0;
    refuseCmd("R9");
    descDims = 3'd6;
    refuseCmd("R9");
    descDims = 3'd3; descBox = {8'd5, 8'd5, 8'd0, 8'd2, 8'd2};
    refuseCmd("R9");

    // Random mix of loads and stores.
    for (int n = 0; n < 40; n++) begin
      randomCmd();
      runCmd(int'($urandom_range(100, 30)));
    end

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule